// File: doc/BRIEF.md
# Core-Local Machine Timer

This block gives a 32-bit core a machine timer: a counter built from two halves that advances on every enabled tick, a compare value also built from two halves, and a level-sensitive timer interrupt request. Software reaches it through a word-wide register port. The counter and both compare halves can be read. Only the compare halves can be written.

The interrupt condition is unusual, and software must take it into account. The request is raised when the upper counter half is strictly greater than the upper compare half. It is also raised when both halves match exactly. An equal upper half with a larger lower half does not raise it. A compare value of zero turns the request off altogether. Offset 0x0000 is reserved for a software interrupt word. It reads as zero and ignores writes.

Top module: `mach_timer`

## Requirements
- R1: After reset the counter and both compare halves are zero, read data is zero and `timer_irq` is low.
- R2: The counter advances by exactly one at each clock edge where `tick_en` is high. It holds its value when `tick_en` is low.
- R3: When the low counter half is all ones on a tick, it becomes zero and the high half increments at the same edge.
- R4: With a nonzero compare, `timer_irq` is high whenever the high counter half is greater than the high compare half.
- R5: With equal high halves, `timer_irq` is high only when the low halves are also equal. It is low whether the low counter half is below or above the low compare half.
- R6: `timer_irq` is low whenever both compare halves are zero.
- R7: A write at offset 0x4000 loads the low compare half and a write at offset 0x4004 loads the high compare half, both at the accepting edge.
- R8: Writes to any other offset are ignored and leave the compare halves and the counter unchanged. This covers 0x0000, the counter offsets and offsets that are not word aligned.
- R9: A read at offset 0x4000, 0x4004, 0xBFF8 (low counter half) or 0xBFFC (high counter half) puts that register's value onto `rsp_rdata` at the accepting edge. The value is the one held just before that edge.
- R10: Reads of 0x0000, of unmapped offsets and of offsets that are not word aligned return zero.
- R11: `timer_irq` is a level that depends only on the current counter and compare registers. Raising the compare above the counter drops it in the cycle that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Byte offset from the block base |
| req_wdata | input | W (32) | Write data |
| rsp_rdata | output | W (32) | Read data, registered |
| timer_irq | output | 1 | Timer interrupt request level |

## Verification
Counter, compare and read-data updates all land at the edge that accepts the tick or the access. The interrupt level follows from the new register values within that same cycle. The bench drives inputs on the falling edge and checks every result 1 ns after the next rising edge. At that point it compares against a model that it advanced once for that edge, with read data taken from the model state before the update. The bench is built with 8-bit halves so that carries and wide-range comparisons occur within a short run.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam logic [31:0] OFS_SWI    = 32'h0000_0000;
  localparam logic [31:0] OFS_CMP_LO = 32'h0000_4000;
  localparam logic [31:0] OFS_CMP_HI = 32'h0000_4004;
  localparam logic [31:0] OFS_CNT_LO = 32'h0000_BFF8;
  localparam logic [31:0] OFS_CNT_HI = 32'h0000_BFFC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SWI, SEL_CMP_LO, SEL_CMP_HI, SEL_CNT_LO, SEL_CNT_HI
  } reg_sel_e;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         lo_wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] add_one(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  assign lo_wrap = tick_en && (&cnt_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (tick_en) begin
      cnt_lo <= add_one(cnt_lo);
      if (lo_wrap) cnt_hi <= add_one(cnt_hi);
    end
  end
endmodule

// File: rtl/mt_compare.sv
module mt_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] cnt_lo,
  input  logic [W-1:0] cnt_hi,
  input  logic [W-1:0] cmp_lo,
  input  logic [W-1:0] cmp_hi,
  output logic         irq
);
  function automatic logic fires(input logic [W-1:0] c_hi, input logic [W-1:0] c_lo,
                                 input logic [W-1:0] k_hi, input logic [W-1:0] k_lo);
    logic armed;
    armed = (k_hi != '0) || (k_lo != '0);
    return armed && ((c_hi > k_hi) || ((c_hi == k_hi) && (c_lo == k_lo)));
  endfunction

  assign irq = fires(cnt_hi, cnt_lo, cmp_hi, cmp_lo);
endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mt_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  input  logic [W-1:0]  cnt_lo,
  input  logic [W-1:0]  cnt_hi,
  output logic [W-1:0]  cmp_lo,
  output logic [W-1:0]  cmp_hi,
  output logic [W-1:0]  rsp_rdata
);
  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    logic [31:0] a32;
    a32 = 32'(a);
    case (a32)
      OFS_SWI:    return SEL_SWI;
      OFS_CMP_LO: return SEL_CMP_LO;
      OFS_CMP_HI: return SEL_CMP_HI;
      OFS_CNT_LO: return SEL_CNT_LO;
      OFS_CNT_HI: return SEL_CNT_HI;
      default:    return SEL_NONE;
    endcase
  endfunction

  reg_sel_e     sel;
  logic [W-1:0] rd_mux;

  assign sel = decode(req_addr);

  always_comb begin
    case (sel)
      SEL_CMP_LO: rd_mux = cmp_lo;
      SEL_CMP_HI: rd_mux = cmp_hi;
      SEL_CNT_LO: rd_mux = cnt_lo;
      SEL_CNT_HI: rd_mux = cnt_hi;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo    <= '0;
      cmp_hi    <= '0;
      rsp_rdata <= '0;
    end else if (req_valid) begin
      if (req_write) begin
        if (sel == SEL_CMP_LO) cmp_lo <= req_wdata;
        if (sel == SEL_CMP_HI) cmp_hi <= req_wdata;
      end else begin
        rsp_rdata <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/mach_timer.sv
module mach_timer #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic [W-1:0]  rsp_rdata,
  output logic          timer_irq
);
  logic [W-1:0] cnt_lo, cnt_hi, cmp_lo, cmp_hi;
  logic         lo_wrap;

  mt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .lo_wrap(lo_wrap)
  );

  mt_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .rsp_rdata(rsp_rdata)
  );

  mt_compare #(.W(W)) u_cmp (
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .irq(timer_irq)
  );
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [W-1:0]  req_wdata,
  input logic [W-1:0]  cnt_lo,
  input logic [W-1:0]  cnt_hi,
  input logic [W-1:0]  cmp_lo,
  input logic [W-1:0]  cmp_hi,
  input logic          lo_wrap,
  input logic          timer_irq
);
  logic [2*W-1:0] cnt_all, cmp_all;
  logic           wr_lo, wr_hi, wr_other;
  assign cnt_all  = {cnt_hi, cnt_lo};
  assign cmp_all  = {cmp_hi, cmp_lo};
  assign wr_lo    = req_valid && req_write && (32'(req_addr) == OFS_CMP_LO);
  assign wr_hi    = req_valid && req_write && (32'(req_addr) == OFS_CMP_HI);
  assign wr_other = req_valid && req_write && !wr_lo && !wr_hi;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_all == $past(cnt_all) + (2*W)'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_all)); // R2
  AST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + W'(1))); // R3
  AST_HI_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_all != '0) && (cnt_hi > cmp_hi)) |-> timer_irq); // R4
  AST_ZERO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_all == '0) |-> !timer_irq); // R6
  AST_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cmp_lo == $past(req_wdata)); // R7
  AST_WR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cmp_hi == $past(req_wdata)); // R7
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_other || !req_valid || !req_write) |=> $stable(cmp_all)); // R8
endmodule

bind mach_timer mt_checker #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
  .lo_wrap(lo_wrap), .timer_irq(timer_irq)
);

// File: tb/test_mach_timer.sv
module test_mach_timer;
  localparam int W  = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic [W-1:0]  rsp_rdata;
  logic          timer_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2*W-1:0] m_cnt = '0;
  logic [2*W-1:0] m_cmp = '0;

  always #2.5 clk = ~clk;

  mach_timer #(.W(W), .AW(AW)) i_mach_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .timer_irq(timer_irq)
  );

  function automatic logic exp_irq(input logic [2*W-1:0] c, input logic [2*W-1:0] k);
    if (k == '0) return 1'b0;
    if (c[2*W-1:W] > k[2*W-1:W]) return 1'b1;
    return c == k;
  endfunction

  function automatic string irq_tag(input logic [2*W-1:0] c, input logic [2*W-1:0] k);
    if (k == '0) return "R6";
    if (c[2*W-1:W] > k[2*W-1:W]) return "R4";
    return "R5";
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
    case (a)
      16'h4000: return m_cmp[W-1:0];
      16'h4004: return m_cmp[2*W-1:W];
      16'hBFF8: return m_cnt[W-1:0];
      16'hBFFC: return m_cnt[2*W-1:W];
      default:  return '0;
    endcase
  endfunction

  function automatic bit is_mapped(input logic [AW-1:0] a);
    return a == 16'h4000 || a == 16'h4004 || a == 16'hBFF8 || a == 16'hBFFC;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit wr, input logic [AW-1:0] a,
                     input logic [W-1:0] d, input bit t, input string tag);
    logic [W-1:0] rd_exp;
    bit           is_rd;
    @(negedge clk);
    req_valid = v; req_write = wr; req_addr = a; req_wdata = d; tick_en = t;
    is_rd  = v && !wr;
    rd_exp = exp_read(a);
    @(posedge clk);
    if (v && wr && a == 16'h4000) m_cmp[W-1:0] = d;
    if (v && wr && a == 16'h4004) m_cmp[2*W-1:W] = d;
    if (t) m_cnt = m_cnt + 1'b1;
    #1;
    if (is_rd) check(tag, 32'(rsp_rdata), 32'(rd_exp));
    check(irq_tag(m_cnt, m_cmp), 32'(timer_irq), 32'(exp_irq(m_cnt, m_cmp)));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] alist [8];
    int s;
    s = $urandom(1234);
    alist = '{16'h4000, 16'h4004, 16'hBFF8, 16'hBFFC, 16'h0000, 16'h4001, 16'h1234, 16'hBFFA};
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq", 32'(timer_irq), 0);
    check("R1 rdata", 32'(rsp_rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: all registers zero after reset
    cyc(1, 0, 16'h4000, 0, 0, "R1");
    cyc(1, 0, 16'h4004, 0, 0, "R1");
    cyc(1, 0, 16'hBFF8, 0, 0, "R1");
    cyc(1, 0, 16'hBFFC, 0, 0, "R1");
    // R10: reserved, unmapped and misaligned reads
    cyc(1, 0, 16'h0000, 0, 1, "R10");
    cyc(1, 0, 16'h4002, 0, 1, "R10");
    cyc(1, 0, 16'h7000, 0, 1, "R10");
    // R2: advance and hold
    for (int i = 0; i < 6; i++) cyc(1, 0, 16'hBFF8, 0, i[0], "R2");
    // R3: run across low-half wraps, reading both halves
    for (int i = 0; i < 600; i++) cyc(1, 0, i[0] ? 16'hBFFC : 16'hBFF8, 0, 1, "R3");
    // R5: equal high halves, low match then pass
    cyc(1, 1, 16'h4004, m_cnt[2*W-1:W], 0, "R7");
    cyc(1, 1, 16'h4000, m_cnt[W-1:0] + 8'd3, 0, "R7");
    cyc(1, 0, 16'h4000, 0, 0, "R7");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, "R5");
    // R4: high compare below high count
    cyc(1, 1, 16'h4004, m_cnt[2*W-1:W] - 8'd1, 0, "R4");
    cyc(1, 1, 16'h4000, 8'hFF, 1, "R4");
    // R11: raising the compare drops the request next cycle
    cyc(1, 1, 16'h4004, 8'hF0, 0, "R11");
    check("R11 drop", 32'(timer_irq), 0);
    // R8: writes elsewhere are ignored
    cyc(1, 1, 16'hBFF8, 8'h55, 0, "R8");
    cyc(1, 1, 16'hBFFC, 8'h55, 0, "R8");
    cyc(1, 1, 16'h0000, 8'h55, 0, "R8");
    cyc(1, 1, 16'h4001, 8'h55, 0, "R8");
    cyc(1, 1, 16'h4006, 8'h55, 0, "R8");
    cyc(1, 0, 16'hBFF8, 0, 0, "R8");
    cyc(1, 0, 16'hBFFC, 0, 0, "R8");
    cyc(1, 0, 16'h4000, 0, 0, "R8");
    cyc(1, 0, 16'h4004, 0, 0, "R8");
    cyc(1, 0, 16'h0000, 0, 0, "R8");
    // R6: zero compare keeps the request low
    cyc(1, 1, 16'h4000, 0, 1, "R6");
    cyc(1, 1, 16'h4004, 0, 1, "R6");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, "R6");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = alist[$urandom_range(0, 7)];
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, a,
          W'($urandom_range(0, 255)), $urandom_range(0, 3) != 0,
          is_mapped(a) ? "R9" : "R10");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule